// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This unit watches one external input pin and, when a chosen kind of edge occurs, stores a snapshot of one of two free-running 16-bit timers. The pin goes through a two-stage synchroniser and an edge detector first. A mode field then decides what counts as an event: each falling edge, each rising edge, or one rising edge in four or in sixteen. Each capture raises a sticky interrupt flag. Software reads the stored value through a small byte-wide register port.

Software programs a control register that holds the mode and the timer choice. It then waits for the interrupt, reads the two capture bytes and clears the flag by writing zero to it. The rising-edge prescale counter is cleared only when the unit is switched off or set to a code that is not a capture mode. A move straight from one prescale ratio to another keeps the old count, so the first capture after such a move can come early.

Top module: `edge_capture_unit`

## Requirements
- R1: A capture stores the full 16-bit value of the selected timer. Its low byte reads at address 2 and its high byte at address 3.
- R2: Control register address 0 holds the mode in bits [3:0]. The codes are 4'b0000 off, 4'b0100 every falling edge, 4'b0101 every rising edge, 4'b0110 every 4th rising edge and 4'b0111 every 16th rising edge. Every other code is a non-capture mode.
- R3: A pin change is sampled on the first rising clock edge after it, and the capture register and flag update on the third.
- R4: In the 4th and 16th modes a capture fires on the rising pin edge that brings the count to the ratio, and the count then returns to zero.
- R5: The prescale counter is zero after reset and is held at zero whenever the mode is not a capture mode.
- R6: A move between capture modes keeps the prescale count. If the count plus one is already at or above the new ratio, the next rising pin edge captures.
- R7: Each capture sets the flag, which reads as bit 0 at address 1 and also drives irq_o. The flag stays set until software clears it.
- R8: Writing address 1 with bit 0 equal to 0 clears the flag, and writing it with bit 0 equal to 1 leaves the flag unchanged. When a capture and a clear fall in the same cycle, the flag ends up set.
- R9: A new capture overwrites an unread value and gives no error indication.
- R10: Control bit 4 selects the timer: 0 selects timer A and 1 selects timer B.
- R11: After reset the control register, flag and capture register all read as zero.
- R12: Writing a new mode does not clear the flag.
- R13: In a non-capture mode, pin edges change neither the capture register nor the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous event pin |
| timer_a_i | input | 16 | Timer A count |
| timer_b_i | input | 16 | Timer B count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Capture flag |

## Verification
If the prescale count is off by even one, the capture comes one rising pin edge too early or too late. The flag then rises in the wrong place and shows the error within three clocks of that pin edge. A stuck timer select or a wrong byte order shows up at the next capture readback. A wrong flag update shows in irq_o one clock after the write or capture that caused it. The bench runs a reference count alongside the design through every mode change, so any stale or lost count is caught at the next capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [3:0] {
    MODE_OFF    = 4'b0000,
    MODE_FALL   = 4'b0100,
    MODE_RISE   = 4'b0101,
    MODE_DIV_LO = 4'b0110,
    MODE_DIV_HI = 4'b0111
  } cap_mode_e;

  localparam int unsigned MODE_W    = 4;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_FLAG = 1;
  localparam int unsigned ADDR_CAP0 = 2;

  function automatic logic mode_is_capture(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sync stages plus one history flop
  logic [STAGES:0] sh_q, sh_d;
  logic            level, prev;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level  = sh_q[STAGES-1];
  assign prev   = sh_q[STAGES];
  assign rise_o = level & ~prev;
  assign fall_o = ~level & prev;
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler
  import cap_pkg::*;
#(
  parameter int unsigned RATIO_LO = 4,
  parameter int unsigned RATIO_HI = 16,
  localparam int unsigned PSC_W   = $clog2(RATIO_HI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              fire_o,
  output logic [PSC_W-1:0]  count_o
);
  logic [PSC_W-1:0] count_q, count_d;
  logic             count_en;
  logic [PSC_W:0]   inc;
  logic [PSC_W:0]   ratio;

  always_comb begin
    inc      = {1'b0, count_q} + 1'b1;
    ratio    = (mode_i == MODE_DIV_HI) ? (PSC_W+1)'(RATIO_HI) : (PSC_W+1)'(RATIO_LO);
    fire_o   = 1'b0;
    count_en = 1'b0;
    count_d  = count_q;
    case (mode_i)
      MODE_FALL: fire_o = fall_i;
      MODE_RISE: fire_o = rise_i;
      MODE_DIV_LO, MODE_DIV_HI: begin
        if (rise_i) begin
          count_en = 1'b1;
          if (inc >= ratio) begin
            fire_o  = 1'b1;
            count_d = '0;
          end else begin
            count_d = inc[PSC_W-1:0];
          end
        end
      end
      default: begin
        count_en = 1'b1;
        count_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned NB     = TW / DW,
  localparam int unsigned AW     = $clog2(ADDR_CAP0 + NB),
  localparam int unsigned CTRL_W = MODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              fire_i,
  input  logic [TW-1:0]     timer_a_i,
  input  logic [TW-1:0]     timer_b_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              src_o,
  output logic              flag_o,
  output logic [TW-1:0]     cap_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic              flag_q, flag_d;
  logic [TW-1:0]     cap_q, cap_d;
  logic              flag_clr;
  logic [DW-1:0]     cap_bytes [NB];
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[DW-1:CTRL_W];

  always_comb begin
    ctrl_en  = wr_en_i && (wr_addr_i == AW'(ADDR_CTRL));
    ctrl_d   = wr_data_i[CTRL_W-1:0];
    flag_clr = wr_en_i && (wr_addr_i == AW'(ADDR_FLAG)) && !wr_data_i[0];
    cap_d    = ctrl_q[MODE_W] ? timer_b_i : timer_a_i;
    if (fire_i)        flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      if (fire_i)  cap_q  <= cap_d;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign cap_bytes[g] = cap_q[g*DW +: DW];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(ADDR_CTRL)) rd_data_o = DW'(ctrl_q);
    if (rd_addr_i == AW'(ADDR_FLAG)) rd_data_o = DW'(flag_q);
    for (int i = 0; i < NB; i++) begin
      if (rd_addr_i == AW'(ADDR_CAP0 + i)) rd_data_o = cap_bytes[i];
    end
  end

  assign mode_o = ctrl_q[MODE_W-1:0];
  assign src_o  = ctrl_q[MODE_W];
  assign flag_o = flag_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RATIO_LO    = 4,
  parameter int unsigned RATIO_HI    = 16,
  localparam int unsigned AW    = $clog2(ADDR_CAP0 + TW / DW),
  localparam int unsigned PSC_W = $clog2(RATIO_HI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic [TW-1:0] timer_a_i,
  input  logic [TW-1:0] timer_b_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  logic              rst_sync_n;
  logic              rise, fall, fire;
  logic [MODE_W-1:0] mode;
  logic              src;
  logic              flag;
  logic [TW-1:0]     cap;
  logic [PSC_W-1:0]  psc_count;

  cap_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cap_edge_detect #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_i),
    .rise_o(rise), .fall_o(fall)
  );

  cap_prescaler #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) psc_i (
    .clk(clk), .rst_n(rst_sync_n), .mode_i(mode),
    .rise_i(rise), .fall_i(fall), .fire_o(fire), .count_o(psc_count)
  );

  cap_regs #(.TW(TW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .fire_i(fire), .timer_a_i(timer_a_i), .timer_b_i(timer_b_i),
    .mode_o(mode), .src_o(src), .flag_o(flag), .cap_o(cap)
  );

  assign irq_o = flag;
endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk
  import cap_pkg::*;
#(
  parameter int unsigned TW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 2,
  parameter int unsigned PSC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              flag,
  input logic              src,
  input logic [MODE_W-1:0] mode,
  input logic [TW-1:0]     cap,
  input logic [TW-1:0]     timer_a,
  input logic [TW-1:0]     timer_b,
  input logic [PSC_W-1:0]  count,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data
);
  logic clr_req;
  assign clr_req = wr_en && (wr_addr == AW'(ADDR_FLAG)) && !wr_data[0];

  assert_capture_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap == (($past(src)) ? $past(timer_b) : $past(timer_a)));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  assert_flag_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_req));

  assert_psc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_is_capture(mode) |=> count == '0);

  assert_no_capture_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_is_capture(mode) |=> ($stable(cap) && !$rose(flag)));
endmodule

bind edge_capture_unit edge_capture_unit_chk #(
  .TW(TW), .DW(DW), .AW(AW), .PSC_W(PSC_W)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .fire(fire), .flag(flag), .src(src),
  .mode(mode), .cap(cap), .timer_a(timer_a_i), .timer_b(timer_b_i),
  .count(psc_count), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i)
);

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] ta = '0, tb = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [3:0]  m_mode = 4'd0;
  logic        m_src = 1'b0;
  int          m_cnt = 0;
  logic        m_pin = 1'b0;
  logic [15:0] m_cap = '0;
  logic        m_flag = 1'b0;

  always #10 clk = ~clk;

  edge_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .timer_a_i(ta), .timer_b_i(tb),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic s, input logic [3:0] m);
    wr(2'd0, {3'b000, s, m});
    m_mode = m; m_src = s;
    if (!is_cap(m)) m_cnt = 0;
  endtask

  task automatic model_edge(input logic v);
    logic r, f, fire;
    r = v & ~m_pin; f = ~v & m_pin; m_pin = v; fire = 1'b0;
    case (m_mode)
      4'b0100: fire = f;
      4'b0101: fire = r;
      4'b0110, 4'b0111: if (r) begin
        if (m_cnt + 1 >= ((m_mode == 4'b0111) ? 16 : 4)) begin fire = 1'b1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      default: m_cnt = 0;
    endcase
    if (fire) begin m_cap = m_src ? tb : ta; m_flag = 1'b1; end
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk);
    pin = v;
    repeat (4) @(posedge clk);
    model_edge(v);
  endtask

  task automatic check_state(input string req);
    logic [7:0] lo, hi, fl;
    rd(2'd2, lo); rd(2'd3, hi); rd(2'd1, fl);
    check(req, {hi, lo}, m_cap);
    check(req, {15'd0, fl[0]}, {15'd0, m_flag});
    check(req, {15'd0, irq}, {15'd0, m_flag});
  endtask

  task automatic clear_flag();
    wr(2'd1, 8'h00);
    m_flag = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R11 reset state
    rd(2'd0, d); check("R11 ctrl", {8'd0, d}, 16'd0);
    check_state("R11 reset");

    // R13 off mode ignores edges
    ta = 16'hA5C3; drive_pin(1'b1); drive_pin(1'b0);
    check_state("R13 off");

    // R2 R10 readback of control
    set_ctrl(1'b1, 4'b0101);
    rd(2'd0, d); check("R2 R10 ctrl readback", {8'd0, d}, 16'h0015);

    // R1 R10 rising capture from timer B
    ta = 16'h1122; tb = 16'hBEEF; drive_pin(1'b1);
    check_state("R1 R10 rise capture B");

    // R3 exact cycle, R8 capture beats clear
    ta = 16'h0F0F; set_ctrl(1'b0, 4'b0100);
    @(negedge clk) pin = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 check("R3 before third edge", {15'd0, irq}, 16'd1);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00; end
    @(posedge clk);
    @(negedge clk) wr_en = 1'b0;
    model_edge(1'b0);
    check_state("R3 R8 capture wins");

    // R8 write of 1 keeps flag, write of 0 clears
    wr(2'd1, 8'h01); check_state("R8 write one");
    clear_flag(); check_state("R8 clear");

    // R4 divide by four, R9 overwrite
    set_ctrl(1'b0, 4'b0110);
    for (int i = 0; i < 8; i++) begin
      ta = 16'h4000 + 16'(i);
      drive_pin(1'b1); drive_pin(1'b0);
    end
    check_state("R4 R9 div4");

    // R12 mode write keeps flag; R6 stale count 16 -> 4
    set_ctrl(1'b0, 4'b0111);
    check_state("R12 mode change");
    clear_flag();
    for (int i = 0; i < 10; i++) begin drive_pin(1'b1); drive_pin(1'b0); end
    check_state("R4 div16 no capture yet");
    set_ctrl(1'b0, 4'b0110);
    ta = 16'h6006; drive_pin(1'b1); drive_pin(1'b0);
    check_state("R6 early capture");

    // R5 non-capture code clears count
    for (int i = 0; i < 3; i++) begin drive_pin(1'b1); drive_pin(1'b0); end
    set_ctrl(1'b0, 4'b1101);
    set_ctrl(1'b0, 4'b0110);
    clear_flag();
    ta = 16'h5555; drive_pin(1'b1); drive_pin(1'b0);
    check_state("R5 count cleared");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) begin
        ta = 16'($urandom); tb = 16'($urandom);
        drive_pin(~m_pin);
      end else if (op < 7) begin
        int r;
        logic [3:0] m;
        r = $urandom_range(0, 9);
        m = (r < 8) ? 4'(4 + r % 4) : 4'($urandom_range(0, 15));
        set_ctrl(1'($urandom_range(0, 1)), m);
      end else if (op < 8) begin
        clear_flag();
      end else begin
        check_state("R1 R4 R7 random");
      end
    end
    check_state("R9 random final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule